// File: doc/BRIEF.md
# Long Rotate Command Splitter

The block takes one rotate request carrying a 64-bit bit count and turns it into a series of hardware rotate commands. No single command moves more than a fixed cap of bits, which is the largest value a 20-bit count field holds. Each command is written as a 64-bit control word to a control register through a simple register-write port. After each write, the block reads a status register through a register-read port until that register reports completion. Only then does the next command go out.

Polling is bounded. Each poll that misses is followed by a programmable number of idle cycles, and a fixed number of attempts is allowed per command. Running out of attempts ends the request as a timeout. A bus error on any read or write ends the request at once.

Requests are taken only while the block is idle. The end of each request is marked by a single-cycle `done`, which carries `error` and `timeout` as qualifiers in the same cycle. The register bus is a plain request/acknowledge handshake. The scan chain that the commands drive lies outside this block.

Top module: `rot_splitter`

## Requirements
- R1: A request with a count of zero issues no bus transaction and ends with `done` high, `error` low and `timeout` low.
- R2: A nonzero count no larger than the cap (0xFFFFF) is issued as exactly one control write carrying the whole count.
- R3: A count above the cap is issued as floor(count / cap) writes of the cap, in order, followed by one write of the remainder. No write is issued when the remainder is zero, so no control write ever carries a zero count.
- R4: Each control write goes to address CTRL_ADDR (default 0x40). Its 64-bit data holds the count in bits 51:32, numbered from bit 0 as the least significant bit, and zero in every other bit.
- R5: After each control write, the block reads address STAT_ADDR (default 0x44) until a read returns bit 55 set (bit 55 is bit 8 counted from the most significant end). The next control write, or the end of the request, follows only after that read.
- R6: After a poll read that returns bit 55 clear, `rd_req` stays low for exactly `gap_cfg` cycles before the next read. A `gap_cfg` of zero selects 125 cycles.
- R7: At most 1000 reads are made per command. If the 1000th read still shows bit 55 clear, the request ends with `done`, `error` and `timeout` all high. A command whose 1000th read shows bit 55 set completes normally.
- R8: A write acknowledged with `wr_err` high, or a read acknowledged with `rd_err` high, ends the request with `done` and `error` high and `timeout` low. No further bus request is made after that.
- R9: `busy` is high from the cycle after a request is accepted until the end of the request. `req_valid` is ignored while `busy` is high, and such a pulse never starts a later request.
- R10: `done` is high for one cycle only. `error` and `timeout` are high only in a cycle where `done` is high, and `timeout` is high only together with `error`.
- R11: After reset, `busy`, `done`, `error`, `timeout`, `wr_req` and `rd_req` are all low.
- R12: A raised `wr_req` or `rd_req` stays high, with stable write data, until the matching acknowledge is seen. `wr_req` and `rd_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a rotate request (taken only while idle) |
| req_count | input | 64 | Total number of bits to rotate |
| gap_cfg | input | 16 | Idle cycles between poll reads; 0 selects 125 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| error | output | 1 | Request ended in failure (valid with done) |
| timeout | output | 1 | Failure was poll exhaustion (valid with done) |
| wr_req | output | 1 | Register write request |
| wr_addr | output | 32 | Register write address |
| wr_data | output | 64 | Register write data |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error, valid with wr_ack |
| rd_req | output | 1 | Register read request |
| rd_addr | output | 32 | Register read address |
| rd_ack | input | 1 | Read acknowledge |
| rd_data | input | 64 | Read data, valid with rd_ack |
| rd_err | input | 1 | Read error, valid with rd_ack |

## Verification
The bench targets several corner cases, and each one catches a specific failure:
- Counts exactly at the cap, one above it, and exact multiples of it. A splitter that miscounts the quotient or emits a zero-length tail would produce an extra or a missing write.
- A count of zero. A design that mishandles it would write a zero command or never finish.
- A command whose completion shows on exactly the 1000th read, and one where completion never shows. An off-by-one attempt counter would turn a success into a timeout, or make 999 or 1001 reads.
- Gap timing, measured from the read port, with an explicit gap and with the zero-selects-default case.
- Bus errors injected mid-request on a write and on a read. An abort that leaks would keep issuing transactions or flag a timeout.
- A start pulse sent while busy. A design that does not ignore it would start a second request.

// File: rtl/rot_splitter_pkg.sv
package rot_splitter_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_WRITE,
    ST_READ,
    ST_GAP
  } rs_state_e;

  typedef enum logic [1:0] {
    END_OK,
    END_BUS,
    END_TMO
  } rs_end_e;

endpackage

// File: rtl/rot_splitter_chunker.sv
// Chooses the next command length from the bits still owed and returns
// what is left afterwards.
module rot_splitter_chunker #(
  parameter int CNT_W   = 64,
  parameter int CHUNK_W = 20
) (
  input  logic [CNT_W-1:0]   remain,
  output logic [CHUNK_W-1:0] chunk,
  output logic [CNT_W-1:0]   rest,
  output logic               empty
);

  localparam logic [CNT_W-1:0] CAP = {{(CNT_W-CHUNK_W){1'b0}}, {CHUNK_W{1'b1}}};

  logic over;

  always_comb begin
    over  = (remain > CAP);
    empty = (remain == '0);
    if (over) begin
      chunk = CAP[CHUNK_W-1:0];
      rest  = remain - CAP;
    end else begin
      chunk = remain[CHUNK_W-1:0];
      rest  = '0;
    end
  end

endmodule

// File: rtl/rot_splitter_poller.sv
// Tracks poll attempts for one command and times the pause between reads.
module rot_splitter_poller #(
  parameter int POLLS       = 1000,
  parameter int GAP_W       = 16,
  parameter int DEFAULT_GAP = 125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             miss,
  input  logic             gap_tick,
  input  logic [GAP_W-1:0] gap_cfg,
  output logic             last_try,
  output logic             gap_expire
);

  localparam int AW = $clog2(POLLS + 1);

  logic [AW-1:0]    attempts;
  logic [GAP_W-1:0] gcnt;
  logic [GAP_W-1:0] gap_eff;

  assign gap_eff    = (gap_cfg == '0) ? GAP_W'(DEFAULT_GAP) : gap_cfg;
  assign last_try   = (attempts == AW'(POLLS - 1));
  assign gap_expire = (gcnt == GAP_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      attempts <= '0;
      gcnt     <= '0;
    end else begin
      if (start) begin
        attempts <= '0;
      end else if (miss) begin
        attempts <= attempts + AW'(1);
      end
      if (miss) begin
        gcnt <= gap_eff;
      end else if (gap_tick && gcnt != '0) begin
        gcnt <= gcnt - GAP_W'(1);
      end
    end
  end

endmodule

// File: rtl/rot_splitter.sv
module rot_splitter
  import rot_splitter_pkg::*;
#(
  parameter int          CNT_W        = 64,
  parameter int          DATA_W       = 64,
  parameter int          ADDR_W       = 32,
  parameter int          CHUNK_W      = 20,
  parameter int          FIELD_MSB_IX = 31,
  parameter int          DONE_MSB_IX  = 8,
  parameter int          POLLS        = 1000,
  parameter int          GAP_W        = 16,
  parameter int          DEFAULT_GAP  = 125,
  parameter logic [31:0] CTRL_ADDR    = 32'h0000_0040,
  parameter logic [31:0] STAT_ADDR    = 32'h0000_0044
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [GAP_W-1:0]  gap_cfg,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              timeout,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  input  logic              wr_err,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err
);

  // Field and flag positions are given MSB-first; convert to LSB indices.
  localparam int FIELD_LSB = DATA_W - 1 - FIELD_MSB_IX;
  localparam int HI_PAD    = DATA_W - FIELD_LSB - CHUNK_W;
  localparam int DONE_BIT  = DATA_W - 1 - DONE_MSB_IX;

  rs_state_e          state;
  logic [CNT_W-1:0]   remain;
  logic [CHUNK_W-1:0] ck_chunk;
  logic [CNT_W-1:0]   ck_rest;
  logic               ck_empty;
  logic               last_try;
  logic               gap_expire;
  logic               pol_start;
  logic               pol_miss;
  logic               gap_tick;
  logic               stat_set;
  logic               unused_rd;

  logic               busy_q, done_q, err_q, tmo_q;
  logic               wr_req_q, rd_req_q;
  logic [DATA_W-1:0]  wr_data_q;

  assign unused_rd = ^rd_data;
  assign stat_set  = rd_data[DONE_BIT];

  rot_splitter_chunker #(
    .CNT_W   (CNT_W),
    .CHUNK_W (CHUNK_W)
  ) u_chunker (
    .remain (remain),
    .chunk  (ck_chunk),
    .rest   (ck_rest),
    .empty  (ck_empty)
  );

  assign pol_start = (state == ST_WRITE) && wr_ack;
  assign pol_miss  = (state == ST_READ) && rd_ack && !rd_err && !stat_set;
  assign gap_tick  = (state == ST_GAP);

  rot_splitter_poller #(
    .POLLS       (POLLS),
    .GAP_W       (GAP_W),
    .DEFAULT_GAP (DEFAULT_GAP)
  ) u_poller (
    .clk        (clk),
    .rst        (rst),
    .start      (pol_start),
    .miss       (pol_miss),
    .gap_tick   (gap_tick),
    .gap_cfg    (gap_cfg),
    .last_try   (last_try),
    .gap_expire (gap_expire)
  );

  function automatic logic [DATA_W-1:0] pack_word(input logic [CHUNK_W-1:0] c);
    pack_word = {{HI_PAD{1'b0}}, c, {FIELD_LSB{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      remain    <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      tmo_q     <= 1'b0;
      wr_req_q  <= 1'b0;
      rd_req_q  <= 1'b0;
      wr_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            remain <= req_count;
            busy_q <= 1'b1;
            state  <= ST_PICK;
          end
        end
        ST_PICK: begin
          if (ck_empty) begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            state  <= ST_IDLE;
          end else begin
            remain    <= ck_rest;
            wr_data_q <= pack_word(ck_chunk);
            wr_req_q  <= 1'b1;
            state     <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_ack) begin
            wr_req_q <= 1'b0;
            if (wr_err) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
              busy_q <= 1'b0;
              state  <= ST_IDLE;
            end else begin
              rd_req_q <= 1'b1;
              state    <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (rd_ack) begin
            rd_req_q <= 1'b0;
            if (rd_err) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
              busy_q <= 1'b0;
              state  <= ST_IDLE;
            end else if (stat_set) begin
              state <= ST_PICK;
            end else if (last_try) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
              tmo_q  <= 1'b1;
              busy_q <= 1'b0;
              state  <= ST_IDLE;
            end else begin
              state <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_expire) begin
            rd_req_q <= 1'b1;
            state    <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign error   = err_q;
  assign timeout = tmo_q;
  assign wr_req  = wr_req_q;
  assign wr_data = wr_data_q;
  assign rd_req  = rd_req_q;
  assign wr_addr = CTRL_ADDR[ADDR_W-1:0];
  assign rd_addr = STAT_ADDR[ADDR_W-1:0];

endmodule

// File: rtl/rot_splitter_checker.sv
module rot_splitter_checker #(
  parameter int DATA_W    = 64,
  parameter int CHUNK_W   = 20,
  parameter int FIELD_LSB = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              timeout,
  input logic              wr_req,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_ack,
  input logic              rd_req,
  input logic              rd_ack
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (error || timeout) |-> done); // R10

  AST_TMO_IS_ERR: assert property (@(posedge clk) disable iff (rst)
    timeout |-> error); // R7

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && rd_req)); // R12

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_data))); // R12

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> rd_req); // R12

  AST_NO_ZERO_CHUNK: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (wr_data[FIELD_LSB +: CHUNK_W] != '0)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!wr_req && !rd_req)); // R9

  AST_END_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!wr_req && !rd_req && !busy)); // R8

endmodule

bind rot_splitter rot_splitter_checker #(
  .DATA_W    (DATA_W),
  .CHUNK_W   (CHUNK_W),
  .FIELD_LSB (FIELD_LSB)
) u_checker (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .error   (error),
  .timeout (timeout),
  .wr_req  (wr_req),
  .wr_data (wr_data),
  .wr_ack  (wr_ack),
  .rd_req  (rd_req),
  .rd_ack  (rd_ack)
);

// File: tb/rot_splitter_tb_top.sv
module rot_splitter_tb_top;

  localparam logic [63:0] CAP     = 64'hF_FFFF;
  localparam logic [31:0] CTRL_A  = 32'h0000_0040;
  localparam logic [31:0] STAT_A  = 32'h0000_0044;
  localparam int          NLOG    = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_count = '0;
  logic [15:0] gap_cfg = 16'd1;
  logic        busy, done, error, timeout;
  logic        wr_req, rd_req;
  logic [31:0] wr_addr, rd_addr;
  logic [63:0] wr_data;
  logic        wr_ack, wr_err, rd_ack, rd_err;
  logic [63:0] rd_data;

  always #4 clk = ~clk;

  rot_splitter dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_count(req_count),
    .gap_cfg(gap_cfg), .busy(busy), .done(done), .error(error),
    .timeout(timeout), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err)
  );

  // configuration driven only by the stimulus process
  logic        clr = 1'b0;
  int          cfg_busy_polls = 0;
  int          cfg_err_wr = 0;
  int          cfg_err_rd = 0;

  // register slave model state
  int          wr_cnt, rd_total, bad_addr, polls_left, wwait, rwait;
  logic [63:0] wlog [NLOG];
  int          rd_per [NLOG];

  always @(posedge clk) begin
    wr_ack <= 1'b0;
    wr_err <= 1'b0;
    rd_ack <= 1'b0;
    rd_err <= 1'b0;
    if (rst || clr) begin
      wr_cnt     <= 0;
      rd_total   <= 0;
      bad_addr   <= 0;
      polls_left <= 0;
      wwait      <= 0;
      rwait      <= 0;
      rd_data    <= '0;
      for (int i = 0; i < NLOG; i++) rd_per[i] <= 0;
    end else begin
      if (wr_req && !wr_ack) begin
        if (wwait > 0) wwait <= wwait - 1;
        else begin
          wr_ack <= 1'b1;
          wr_err <= ((wr_cnt + 1) == cfg_err_wr);
          if (wr_cnt < NLOG) wlog[wr_cnt] <= wr_data;
          if (wr_addr != CTRL_A) bad_addr <= bad_addr + 1;
          wr_cnt     <= wr_cnt + 1;
          polls_left <= cfg_busy_polls;
          wwait      <= int'($urandom % 3);
        end
      end
      if (rd_req && !rd_ack) begin
        if (rwait > 0) rwait <= rwait - 1;
        else begin
          rd_ack <= 1'b1;
          rd_err <= ((rd_total + 1) == cfg_err_rd);
          if (rd_addr != STAT_A) bad_addr <= bad_addr + 1;
          if (wr_cnt >= 1 && wr_cnt <= NLOG) rd_per[wr_cnt-1] <= rd_per[wr_cnt-1] + 1;
          rd_total <= rd_total + 1;
          if (polls_left == 0)
            rd_data <= {$urandom, $urandom} | (64'h1 << 55);
          else begin
            rd_data    <= {$urandom, $urandom} & ~(64'h1 << 55);
            polls_left <= polls_left - 1;
          end
          rwait <= int'($urandom % 3);
        end
      end
    end
  end

  // read-gap tracker: length of rd_req low runs between two reads of a command
  logic prev_rd;
  bit   trk;
  int   run_len, run_n, run_bad, exp_gap;

  always @(negedge clk) begin
    if (rst || clr) begin
      prev_rd <= 1'b0;
      trk     <= 1'b0;
      run_len <= 0;
      run_n   <= 0;
      run_bad <= 0;
    end else begin
      prev_rd <= rd_req;
      if (wr_req) trk <= 1'b0;
      else if (prev_rd && !rd_req) begin
        trk     <= 1'b1;
        run_len <= 1;
      end else if (trk && !rd_req) run_len <= run_len + 1;
      else if (trk && !prev_rd && rd_req) begin
        trk   <= 1'b0;
        run_n <= run_n + 1;
        if (run_len != exp_gap) run_bad <= run_bad + 1;
      end
    end
  end

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;
  longint cycles = 0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 190000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    finish_run();
  end

  // one request; ovr_wr / ovr_rd of -1 mean "derive from the count"
  task automatic run_req(input logic [63:0] cnt, input logic [15:0] gap, input int polls,
                         input int err_wr, input int err_rd, input bit exp_err,
                         input bit exp_tmo, input int ovr_wr, input int ovr_rd,
                         input bit junk_pulse, input string tag);
    logic [63:0] rem, c;
    logic [63:0] expw [NLOG];
    int nexp, ewr, erd, waited, per_bad;
    bit got_err, got_tmo, seen;
    @(negedge clk);
    cfg_busy_polls = polls;
    cfg_err_wr = err_wr;
    cfg_err_rd = err_rd;
    gap_cfg = gap;
    exp_gap = (gap == 0) ? 125 : int'(gap);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    req_valid = 1'b1;
    req_count = cnt;
    @(negedge clk);
    req_valid = 1'b0;
    req_count = '0;
    if (junk_pulse) begin
      chk(busy == 1'b1, {tag, " R9 busy after accept"}, busy, 1);
      repeat (2) @(negedge clk);
      req_valid = 1'b1;
      req_count = 64'd7;
      @(negedge clk);
      req_valid = 1'b0;
      req_count = '0;
    end
    nexp = 0;
    rem = cnt;
    while (rem != 0 && nexp < NLOG) begin
      c = (rem > CAP) ? CAP : rem;
      expw[nexp] = c << 32;
      rem = rem - c;
      nexp++;
    end
    seen = 0;
    waited = 0;
    while (!seen && waited < 20000) begin
      if (done) begin
        seen = 1;
        got_err = error;
        got_tmo = timeout;
      end else begin
        @(negedge clk);
        waited++;
      end
    end
    chk(seen, {tag, " done seen"}, seen, 1);
    if (!seen) return;
    chk(got_err == exp_err, {tag, " R8 error flag"}, got_err, exp_err);
    chk(got_tmo == exp_tmo, {tag, " R7 timeout flag"}, got_tmo, exp_tmo);
    ewr = (ovr_wr >= 0) ? ovr_wr : nexp;
    erd = (ovr_rd >= 0) ? ovr_rd : nexp * (polls + 1);
    chk(wr_cnt == ewr, {tag, " R3 write count"}, wr_cnt, ewr);
    chk(rd_total == erd, {tag, " R5 read count"}, rd_total, erd);
    for (int i = 0; i < wr_cnt && i < nexp && i < NLOG; i++)
      chk(wlog[i] == expw[i], {tag, " R4 control word"}, wlog[i], expw[i]);
    chk(bad_addr == 0, {tag, " R4 bus address"}, bad_addr, 0);
    if (!exp_err) begin
      per_bad = 0;
      for (int i = 0; i < nexp && i < NLOG; i++) if (rd_per[i] != polls + 1) per_bad++;
      chk(per_bad == 0, {tag, " R5 reads per command"}, per_bad, 0);
    end
    if (run_n > 0) chk(run_bad == 0, {tag, " R6 poll gap"}, run_bad, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {tag, " R10 done single pulse"}, {done, busy}, 0);
    repeat (4) begin
      @(negedge clk);
      if (wr_req || rd_req) seen = 0;
    end
    chk(seen, {tag, " R9 quiet after end"}, {wr_req, rd_req}, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240607);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, error, timeout, wr_req, rd_req} == 6'b0, "R11 reset state",
        {busy, done, error, timeout, wr_req, rd_req}, 0);
    rst = 1'b0;
    @(negedge clk);

    run_req(64'd0, 16'd1, 0, 0, 0, 0, 0, -1, -1, 0, "R1 zero count");
    run_req(64'd1, 16'd3, 2, 0, 0, 0, 0, -1, -1, 0, "R2 count one");
    run_req(CAP, 16'd1, 0, 0, 0, 0, 0, -1, -1, 0, "R2 count at cap");
    run_req(CAP + 1, 16'd2, 1, 0, 0, 0, 0, -1, -1, 0, "R3 cap plus one");
    run_req(CAP * 2, 16'd1, 0, 0, 0, 0, 0, -1, -1, 0, "R3 exact multiple");
    run_req(CAP * 3 + 7, 16'd0, 1, 0, 0, 0, 0, -1, -1, 0, "R6 default gap");
    for (int k = 0; k < 12; k++) begin
      logic [63:0] rc;
      rc = (k % 3 == 0) ? 64'(1 + $urandom % 50) : 64'($urandom % (5 * 32'hF_FFFF)) + 1;
      run_req(rc, 16'(1 + $urandom % 5), int'($urandom % 4), 0, 0, 0, 0, -1, -1, 0,
              "R3 random count");
    end
    run_req(64'd9, 16'd1, 999, 0, 0, 0, 0, -1, -1, 0, "R7 done on last try");
    run_req(64'd10, 16'd1, 2000, 0, 0, 1, 1, 1, 1000, 0, "R7 poll timeout");
    run_req(CAP * 2 + 3, 16'd2, 0, 2, 0, 1, 0, 2, 1, 0, "R8 write error");
    run_req(64'd33, 16'd2, 5, 0, 3, 1, 0, 1, 3, 0, "R8 read error");
    run_req(CAP + 1, 16'd4, 3, 0, 0, 0, 0, -1, -1, 1, "R9 ignore while busy");
    run_req(64'd0, 16'd1, 0, 0, 0, 0, 0, -1, -1, 0, "R1 zero after ignore");
    finish_run();
  end

endmodule